// File: doc/BRIEF.md
# Addressable RGB LED Waveform Encoder

The block turns a stream of 32-bit pixel words into the one-wire pulse-width waveform that chained addressable RGB LEDs expect. Each pixel word holds three 8-bit colour channels. A 3-bit order mode decides the order in which the channels go out on the wire. Every bit is sent as a high phase followed by a low phase. The lengths of these phases are runtime cycle counts, set separately for a one bit and for a zero bit. After the last pixel of a frame, the line is held low for a programmable latch gap, and a one-cycle transfer-finished pulse follows.

Pixel words are popped from an external transmit FIFO through a valid/ready handshake. Software programs the frame length, the order mode and the timing counts. It then raises the enable input, and each rising edge of enable starts one frame. If the FIFO runs dry in the middle of a frame, the encoder waits with the line low and continues when data arrives. Dropping enable aborts the frame at once.

Top module: `ledWaveEncoder`

## Requirements
- R1: After reset, serOut, pixReady and xferDone are all low.
- R2: A frame starts only on a rising edge of enable while idle. Holding enable high after a frame has finished starts nothing: pixReady stays low and the line stays low.
- R3: The channels are taken from word bits 23:16 (first colour), 15:8 (second colour) and 7:0 (third colour). Bits 31:24 have no effect on the waveform. Each channel is sent most significant bit first, so 24 bits are sent per pixel.
- R4: orderMode picks the channel order on the wire, where first/second/third are written r/g/b: 0=rgb, 1=rbg, 2=grb, 3=gbr, 4=brg, 5=bgr. Codes 6 and 7 behave as grb.
- R5: A one bit is high for t1High cycles and then low for t1Low cycles.
- R6: A zero bit is high for t0High cycles and then low for t0Low cycles.
- R7: Any timing or latch count of zero acts as a count of one cycle.
- R8: Exactly frameLen pixel words are accepted and sent per frame. With frameLen of 0, no word is accepted and the frame goes straight to the latch gap.
- R9: After the low phase of the last bit, the line stays low for latchCount further cycles. xferDone is then high for exactly one cycle, and the block returns to idle.
- R10: When no pixel word is offered between pixels in a frame, the line is held low and pixReady stays high. The pixel is not counted. The frame resumes when a word arrives.
- R11: With enable low, the line is low from the next cycle on. Any frame in progress is abandoned without an xferDone pulse.
- R12: When the next word is offered in time, its first high phase begins in the cycle right after the previous pixel's last low phase, so that low phase keeps its programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Rising edge starts a frame; low aborts |
| frameLen | input | 13 | Pixel words per frame |
| orderMode | input | 3 | Channel order on the wire |
| t1High | input | 6 | High cycles of a one bit |
| t1Low | input | 5 | Low cycles of a one bit |
| t0High | input | 5 | High cycles of a zero bit |
| t0Low | input | 6 | Low cycles of a zero bit |
| latchCount | input | 13 | Low cycles of the end-of-frame gap |
| pixValid | input | 1 | FIFO offers a pixel word |
| pixData | input | 32 | Pixel word |
| pixReady | output | 1 | Encoder takes the offered word this cycle |
| serOut | output | 1 | Serial LED line |
| xferDone | output | 1 | One-cycle transfer-finished pulse |

## Verification
The end of a pixel's last low phase and the acceptance of the next pixel word share one cycle: the pixel counter advances while the shift register reloads. Frames of several back-to-back pixels provoke this, and each inter-pixel low phase is judged by its exact length. Deliberately withholding the second word moves the handshake into a separate wait state. That low gap must then grow, and the frame must still end after exactly two pixels. The drop of enable can also coincide with a pending handshake. An abort in mid-frame checks that the line falls and that no word is taken or finish pulse given afterwards.

// File: rtl/ledEnc_pkg.sv
package ledEnc_pkg;

  localparam int NUM_CH = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_HIGH,
    ST_LOW,
    ST_LATCH,
    ST_DONE
  } encState_t;

  typedef struct packed {
    logic clearPix;
    logic loadPix;
    logic nextBit;
    logic toLow;
    logic toLatch;
    logic tick;
    logic pixDone;
  } encStrobe_t;

  localparam logic [2:0] ORD_RGB = 3'd0;
  localparam logic [2:0] ORD_RBG = 3'd1;
  localparam logic [2:0] ORD_GRB = 3'd2;
  localparam logic [2:0] ORD_GBR = 3'd3;
  localparam logic [2:0] ORD_BRG = 3'd4;
  localparam logic [2:0] ORD_BGR = 3'd5;

endpackage

// File: rtl/ledEncDatapath.sv
module ledEncDatapath
  import ledEnc_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 13,
  parameter int LONG_W  = 6,
  parameter int SHORT_W = 5,
  parameter int LATCH_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  encStrobe_t         strb,
  input  logic [WORD_W-1:0]  pixData,
  input  logic [2:0]         orderMode,
  input  logic [LONG_W-1:0]  t1High,
  input  logic [SHORT_W-1:0] t1Low,
  input  logic [SHORT_W-1:0] t0High,
  input  logic [LONG_W-1:0]  t0Low,
  input  logic [LATCH_W-1:0] latchCount,
  input  logic [LEN_W-1:0]   frameLen,
  output logic               cntZero,
  output logic               lastBit,
  output logic               lastPix,
  output logic               frameEmpty
);

  localparam int PIX_BITS = NUM_CH * CH_W;
  localparam int IDX_W    = $clog2(PIX_BITS);
  localparam int CNT_W    = (LATCH_W > LONG_W) ? LATCH_W : LONG_W;

  // Channel split: index 0 is the first colour (top channel of the word)
  logic [CH_W-1:0] chan [NUM_CH];
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : gSplit
      assign chan[g] = pixData[(NUM_CH-1-g)*CH_W +: CH_W];
    end
    if (WORD_W > PIX_BITS) begin : gSpare
      logic unusedSpare;
      assign unusedSpare = ^pixData[WORD_W-1:PIX_BITS];
    end
  endgenerate

  logic [PIX_BITS-1:0] ordered;
  always_comb begin
    unique case (orderMode)
      ORD_RGB: ordered = {chan[0], chan[1], chan[2]};
      ORD_RBG: ordered = {chan[0], chan[2], chan[1]};
      ORD_GBR: ordered = {chan[1], chan[2], chan[0]};
      ORD_BRG: ordered = {chan[2], chan[0], chan[1]};
      ORD_BGR: ordered = {chan[2], chan[1], chan[0]};
      default: ordered = {chan[1], chan[0], chan[2]};
    endcase
  end

  function automatic logic [CNT_W-1:0] lessOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [PIX_BITS-1:0] shReg;
  logic [IDX_W-1:0]    bitIdx;
  logic [CNT_W-1:0]    cnt;
  logic [LEN_W-1:0]    pixCnt;

  logic [CNT_W-1:0] hiOne, hiZero, loOne, loZero, latchM1;
  assign hiOne   = lessOne(CNT_W'(t1High));
  assign hiZero  = lessOne(CNT_W'(t0High));
  assign loOne   = lessOne(CNT_W'(t1Low));
  assign loZero  = lessOne(CNT_W'(t0Low));
  assign latchM1 = lessOne(CNT_W'(latchCount));

  logic curBit, newBit, followBit;
  assign curBit    = shReg[PIX_BITS-1];
  assign followBit = shReg[PIX_BITS-2];
  assign newBit    = ordered[PIX_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      bitIdx <= '0;
      cnt    <= '0;
      pixCnt <= '0;
    end else begin
      if (strb.clearPix) pixCnt <= '0;
      else if (strb.pixDone) pixCnt <= pixCnt + 1'b1;

      if (strb.loadPix) begin
        shReg  <= ordered;
        bitIdx <= IDX_W'(PIX_BITS - 1);
        cnt    <= newBit ? hiOne : hiZero;
      end else if (strb.nextBit) begin
        shReg  <= {shReg[PIX_BITS-2:0], 1'b0};
        bitIdx <= bitIdx - 1'b1;
        cnt    <= followBit ? hiOne : hiZero;
      end else if (strb.toLow) begin
        cnt <= curBit ? loOne : loZero;
      end else if (strb.toLatch) begin
        cnt <= latchM1;
      end else if (strb.tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cntZero    = (cnt == '0);
  assign lastBit    = (bitIdx == '0);
  assign lastPix    = ((pixCnt + 1'b1) == frameLen);
  assign frameEmpty = (frameLen == '0);

  // R7: the control never counts down a phase that is already at its last cycle
  p_tick_live_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |-> (cnt != '0));

  // R12: at most one counter action is requested per cycle
  p_one_action_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadPix, strb.nextBit, strb.toLow, strb.toLatch, strb.tick}));

endmodule

// File: rtl/ledEncCtrl.sv
module ledEncCtrl
  import ledEnc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       pixValid,
  input  logic       frameEmpty,
  input  logic       cntZero,
  input  logic       lastBit,
  input  logic       lastPix,
  output encStrobe_t strb,
  output logic       pixReady,
  output logic       lineHigh,
  output logic       xferDone
);

  encState_t state, nextState;
  logic      enPrev;

  always_comb begin
    strb      = '0;
    pixReady  = 1'b0;
    nextState = state;
    if (!enable && state != ST_IDLE) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (enable && !enPrev) begin
            strb.clearPix = 1'b1;
            if (frameEmpty) begin
              strb.toLatch = 1'b1;
              nextState    = ST_LATCH;
            end else begin
              nextState = ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          pixReady = 1'b1;
          if (pixValid) begin
            strb.loadPix = 1'b1;
            nextState    = ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (cntZero) begin
            strb.toLow = 1'b1;
            nextState  = ST_LOW;
          end else begin
            strb.tick = 1'b1;
          end
        end
        ST_LOW: begin
          if (!cntZero) begin
            strb.tick = 1'b1;
          end else if (!lastBit) begin
            strb.nextBit = 1'b1;
            nextState    = ST_HIGH;
          end else begin
            strb.pixDone = 1'b1;
            if (lastPix) begin
              strb.toLatch = 1'b1;
              nextState    = ST_LATCH;
            end else begin
              pixReady = 1'b1;
              if (pixValid) begin
                strb.loadPix = 1'b1;
                nextState    = ST_HIGH;
              end else begin
                nextState = ST_FETCH;
              end
            end
          end
        end
        ST_LATCH: begin
          if (cntZero) nextState = ST_DONE;
          else strb.tick = 1'b1;
        end
        ST_DONE: nextState = ST_IDLE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      enPrev <= 1'b0;
    end else begin
      state  <= nextState;
      enPrev <= enable;
    end
  end

  assign lineHigh = (state == ST_HIGH);
  assign xferDone = (state == ST_DONE);

  // R9: the finish pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R9: the finish pulse only follows the latch gap
  p_done_after_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferDone) |-> $past(state) == ST_LATCH);

  // R12: an accepted word drives its first high phase in the next cycle
  p_accept_high_r12: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && pixReady) |=> lineHigh);

endmodule

// File: rtl/ledWaveEncoder.sv
module ledWaveEncoder
  import ledEnc_pkg::*;
#(
  parameter int CH_W    = 8,
  parameter int WORD_W  = 32,
  parameter int LEN_W   = 13,
  parameter int LONG_W  = 6,
  parameter int SHORT_W = 5,
  parameter int LATCH_W = 13
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [LEN_W-1:0]   frameLen,
  input  logic [2:0]         orderMode,
  input  logic [LONG_W-1:0]  t1High,
  input  logic [SHORT_W-1:0] t1Low,
  input  logic [SHORT_W-1:0] t0High,
  input  logic [LONG_W-1:0]  t0Low,
  input  logic [LATCH_W-1:0] latchCount,
  input  logic               pixValid,
  input  logic [WORD_W-1:0]  pixData,
  output logic               pixReady,
  output logic               serOut,
  output logic               xferDone
);

  encStrobe_t strb;
  logic cntZero, lastBit, lastPix, frameEmpty;

  ledEncCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .pixValid  (pixValid),
    .frameEmpty(frameEmpty),
    .cntZero   (cntZero),
    .lastBit   (lastBit),
    .lastPix   (lastPix),
    .strb      (strb),
    .pixReady  (pixReady),
    .lineHigh  (serOut),
    .xferDone  (xferDone)
  );

  ledEncDatapath #(
    .CH_W   (CH_W),
    .WORD_W (WORD_W),
    .LEN_W  (LEN_W),
    .LONG_W (LONG_W),
    .SHORT_W(SHORT_W),
    .LATCH_W(LATCH_W)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pixData   (pixData),
    .orderMode (orderMode),
    .t1High    (t1High),
    .t1Low     (t1Low),
    .t0High    (t0High),
    .t0Low     (t0Low),
    .latchCount(latchCount),
    .frameLen  (frameLen),
    .cntZero   (cntZero),
    .lastBit   (lastBit),
    .lastPix   (lastPix),
    .frameEmpty(frameEmpty)
  );

  // R11: a low enable forces the line low in the following cycle
  p_disabled_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !serOut);

  // R10: while waiting for a word the line stays low
  p_stall_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pixReady && !pixValid) |=> !serOut);

endmodule

// File: tb/ledWaveEncoder_test.sv
`timescale 1ns/1ps
module ledWaveEncoder_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [12:0] frameLen = '0;
  logic [2:0]  orderMode = 3'd2;
  logic [5:0]  t1High = 6'd6;
  logic [4:0]  t1Low = 5'd3;
  logic [4:0]  t0High = 5'd2;
  logic [5:0]  t0Low = 6'd5;
  logic [12:0] latchCount = 13'd20;
  logic        pixValid;
  logic [31:0] pixData;
  logic        pixReady, serOut, xferDone;

  always #10 clk = ~clk;

  ledWaveEncoder uut (
    .clk(clk), .rstN(rstN), .enable(enable), .frameLen(frameLen),
    .orderMode(orderMode), .t1High(t1High), .t1Low(t1Low),
    .t0High(t0High), .t0Low(t0Low), .latchCount(latchCount),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .serOut(serOut), .xferDone(xferDone)
  );

  // pixel source
  logic [31:0] pixMem [0:7];
  int rdIdx = 0;
  int availCnt = 0;
  logic srcReset = 1'b0;
  assign pixValid = (rdIdx < availCnt);
  assign pixData  = pixMem[rdIdx & 7];
  always @(posedge clk) begin
    if (srcReset) rdIdx <= 0;
    else if (pixValid && pixReady) rdIdx <= rdIdx + 1;
  end

  // waveform monitor
  int hiLen [0:127];
  int loLen [0:127];
  int nBits = 0, run = 0, doneSeen = 0, doneLow = -1, readySeen = 0;
  logic prevS = 1'b0;
  logic monClr = 1'b0;
  always @(negedge clk) begin
    if (monClr) begin
      nBits = 0; run = 0; prevS = 1'b0; doneSeen = 0; doneLow = -1; readySeen = 0;
    end else begin
      if (pixReady) readySeen++;
      if (xferDone) begin doneSeen++; doneLow = run; end
      if (serOut != prevS) begin
        if (prevS) begin
          if (nBits < 128) hiLen[nBits] = run;
          nBits++;
        end else if (nBits > 0 && nBits <= 128) begin
          loLen[nBits-1] = run;
        end
        run = 1;
      end else begin
        run++;
      end
      prevS = serOut;
    end
  end

  int total = 0, bad = 0, cyc = 0;
  bit wdFired = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wdFired) begin
      wdFired = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mx1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] expStream(input logic [31:0] w, input logic [2:0] m);
    logic [7:0] r, g, b;
    r = w[23:16]; g = w[15:8]; b = w[7:0];
    case (m)
      3'd0: return {r, g, b};
      3'd1: return {r, b, g};
      3'd3: return {g, b, r};
      3'd4: return {b, r, g};
      3'd5: return {b, g, r};
      default: return {g, r, b};
    endcase
  endfunction

  task automatic startFrame(input int n, input int avail);
    @(posedge clk); #1;
    frameLen = 13'(n); availCnt = avail; srcReset = 1'b1; monClr = 1'b1;
    @(posedge clk); #1;
    srcReset = 1'b0; monClr = 1'b0; enable = 1'b1;
  endtask

  task automatic waitDone(output int ok);
    int k = 0;
    while (doneSeen == 0 && k < 20000) begin
      @(negedge clk); k++;
    end
    ok = (doneSeen != 0) ? 1 : 0;
  endtask

  task automatic stopFrame();
    @(posedge clk); #1 enable = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic checkWave(input string req, input int n, input int stallBit);
    int mism = 0;
    int lastLow = 0;
    logic [23:0] s;
    chk(req, "bit count", nBits, 24 * n);
    for (int i = 0; i < 24 * n; i++) begin
      int eh, el;
      logic bv;
      s  = expStream(pixMem[i / 24], orderMode);
      bv = s[23 - (i % 24)];
      eh = bv ? mx1(int'(t1High)) : mx1(int'(t0High));
      el = bv ? mx1(int'(t1Low)) : mx1(int'(t0Low));
      if (hiLen[i] != eh) mism++;
      if (i == 24 * n - 1) lastLow = el;
      else if (i == stallBit) begin
        if (loLen[i] <= el) mism++;
      end else if (loLen[i] != el) mism++;
    end
    chk(req, "phase length mismatches", mism, 0);
    chk("R9", "low cycles before finish pulse", doneLow, lastLow + mx1(int'(latchCount)));
    chk("R9", "finish pulse count", doneSeen, 1);
  endtask

  task automatic runFrame(input string req, input int n);
    int ok, rs;
    startFrame(n, n);
    waitDone(ok);
    chk(req, "frame finished", ok, 1);
    checkWave(req, n, -1);
    rs = readySeen;
    repeat (30) @(negedge clk);
    chk("R2", "no restart with enable held high", (readySeen - rs) + int'(serOut), 0);
    stopFrame();
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "serOut in reset", int'(serOut), 0);
    chk("R1", "pixReady in reset", int'(pixReady), 0);
    chk("R1", "xferDone in reset", int'(xferDone), 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "serOut after reset", int'(serOut), 0);
    chk("R1", "pixReady after reset", int'(pixReady), 0);
  endtask

  task automatic testTiming();
    pixMem[0] = 32'h00_F0_0F_A5;
    orderMode = 3'd2;
    runFrame("R5 R6", 1);
  endtask

  task automatic testSpareByte();
    pixMem[0] = 32'hFF_3C_C3_81;
    runFrame("R3", 1);
    pixMem[0] = 32'h00_3C_C3_81;
    runFrame("R3", 1);
  endtask

  task automatic testOrders();
    pixMem[0] = 32'h5A_E1_4B_96;
    for (int m = 0; m < 8; m++) begin
      orderMode = 3'(m);
      runFrame("R4", 1);
    end
    orderMode = 3'd2;
  endtask

  task automatic testMulti();
    pixMem[0] = 32'h00_80_01_FF;
    pixMem[1] = 32'h00_00_FE_7F;
    pixMem[2] = 32'hAB_55_AA_33;
    runFrame("R8 R12", 3);
  endtask

  task automatic testZeroCounts();
    t1High = '0; t1Low = '0; t0High = '0; t0Low = '0; latchCount = '0;
    pixMem[0] = 32'h00_C5_3A_96;
    runFrame("R7", 1);
    t1High = 6'd6; t1Low = 5'd3; t0High = 5'd2; t0Low = 6'd5; latchCount = 13'd20;
  endtask

  task automatic testEmptyFrame();
    int ok;
    startFrame(0, 0);
    waitDone(ok);
    chk("R8", "empty frame finished", ok, 1);
    chk("R8", "bits sent in empty frame", nBits, 0);
    chk("R8", "words accepted in empty frame", readySeen, 0);
    stopFrame();
  endtask

  task automatic testUnderflow();
    int ok;
    pixMem[0] = 32'h00_12_34_56;
    pixMem[1] = 32'h00_F1_E2_D3;
    startFrame(2, 1);
    repeat (300) @(negedge clk);
    chk("R10", "line low while waiting", int'(serOut), 0);
    chk("R10", "ready held while waiting", int'(pixReady), 1);
    chk("R10", "no finish while waiting", doneSeen, 0);
    @(posedge clk); #1 availCnt = 2;
    waitDone(ok);
    chk("R10", "frame finished after wait", ok, 1);
    checkWave("R10", 2, 23);
    stopFrame();
  endtask

  task automatic testAbort();
    pixMem[0] = 32'h00_FF_FF_FF;
    pixMem[1] = 32'h00_FF_FF_FF;
    pixMem[2] = 32'h00_FF_FF_FF;
    startFrame(3, 3);
    repeat (60) @(posedge clk);
    #1 enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R11", "line low after abort", int'(serOut), 0);
    chk("R11", "ready low after abort", int'(pixReady), 0);
    repeat (100) @(negedge clk);
    chk("R11", "no finish pulse after abort", doneSeen, 0);
    chk("R11", "line stays low while disabled", int'(serOut), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) pixMem[i] = '0;
    testReset();
    testTiming();
    testSpareByte();
    testOrders();
    testMulti();
    testZeroCounts();
    testEmptyFrame();
    testUnderflow();
    testAbort();
    pixMem[0] = 32'h00_0F_F0_3C;
    runFrame("R11", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule